// File: doc/BRIEF.md
# Event Channel Security Gate

This block sits between a set of event-producing peripherals, a bank of event-routing channels and the peripherals or group tasks that consume channel events. It holds a per-channel security mask and uses it to decide which connections may carry events. A publisher whose transfers are non-secure cannot drive a secure channel. A non-secure subscriber receives nothing from a secure channel. Channel groups are handled the same way: a group counts as secure as soon as any of its member channels is secure.

The block also holds the state of the channel controller. This is the per-channel enable vector and the group membership registers. It serves register accesses to that state over a simple single-cycle bus that carries a transfer security flag. Secure transfers reach every bit. Non-secure transfers are masked silently, bit by bit. Secure bit positions read as zero and ignore writes. Secure groups cannot be read, written or triggered. No fault or error indication is ever raised.

Group tasks can be started in two ways. A register write can start them, or an event on a subscribed channel can start them. Either way, a group task sets or clears every member enable in one cycle.

Top module: `evt_sec_gate`

## Requirements
- R1: Reset state:
  - The security mask is all ones, so every channel is secure. Bit value 1 means secure.
  - The lock bit is 0.
  - All channel enables are 0.
  - All group membership registers are 0.
- R2: Mask and lock registers:
  - The security mask is at word address 3. The lock bit is bit 0 at address 4.
  - Only secure writes change either register. Non-secure writes to them have no effect.
  - A secure write of 1 to the lock bit sets it, and only reset clears it.
  - While the lock bit is set, writes to the mask are ignored.
- R3: Channel event output:
  - chan_evt_o[c] is asserted in the same cycle when channel c is enabled and some publisher strobes with channel index c.
  - The publish passes only if that publisher is secure or channel c is non-secure. A non-secure publish onto a secure channel is dropped.
  - A disabled channel carries no event.
- R4: Subscriber output: sub_evt_o[s] is 1 exactly when all of these hold in the same cycle:
  - sub_en_i[s] is 1.
  - The selected channel carries an event.
  - The subscriber is secure, or the selected channel is non-secure.
- R5: Enable registers:
  - Address 0 writes the enable vector. Address 1 sets enables with write-one. Address 2 clears enables with write-one.
  - A non-secure write leaves the enables of secure channels unchanged. A secure write reaches all channels.
  - The new enable vector appears on chan_en_o one cycle after the write.
- R6: Reading addresses 0, 1 and 2 returns the enable vector. A non-secure read returns 0 in every secure channel position.
- R7: Group configuration registers:
  - Group g's membership register sits at address 16+g.
  - The group is secure when any member channel is secure, whether or not that channel is enabled.
  - A non-secure read of a secure group returns 0, and a non-secure write to it is ignored.
- R8: Group tasks by register:
  - Writing bit 0 = 1 to address 32+g sets every member enable of group g on the next cycle.
  - Writing bit 0 = 1 to address 48+g clears every member enable of group g on the next cycle.
  - Non-secure task writes to a secure group are ignored.
- R9: Group tasks by event:
  - An event on the channel subscribed for a group's enable or disable task triggers that task.
  - The event is ignored when the group is secure and the channel is non-secure.
  - An event on a secure channel triggers both secure and non-secure groups.
- R10: When several updates land in one cycle, they apply in this order:
  1. The register write to the enable vector.
  2. The group disables.
  3. The group enables, so an enable wins over a disable.
- R11: The following return 0 on bus_rdata_o:
  - Any cycle without a read.
  - Reads of the task addresses.
  - Reads of unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Register access valid this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_secure_i | input | 1 | 1 = secure transfer |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | NUM_CH | Write data |
| bus_rdata_o | output | NUM_CH | Masked read data, combinational |
| pub_evt_i | input | NUM_PUB | Publish strobe per publisher |
| pub_chan_i | input | NUM_PUB*CH_W | Target channel per publisher |
| pub_secure_i | input | NUM_PUB | Security attribute per publisher |
| sub_en_i | input | NUM_SUB | Subscription enable per subscriber |
| sub_chan_i | input | NUM_SUB*CH_W | Subscribed channel per subscriber |
| sub_secure_i | input | NUM_SUB | Security attribute per subscriber |
| sub_evt_o | output | NUM_SUB | Gated event per subscriber |
| gen_sub_en_i | input | NUM_GRP | Group enable task subscription valid |
| gen_sub_chan_i | input | NUM_GRP*CH_W | Channel driving each group enable task |
| gdis_sub_en_i | input | NUM_GRP | Group disable task subscription valid |
| gdis_sub_chan_i | input | NUM_GRP*CH_W | Channel driving each group disable task |
| chan_evt_o | output | NUM_CH | Gated event per channel |
| chan_en_o | output | NUM_CH | Channel enable vector |

## Verification
The bench builds the block with 8 channels, 4 groups, 2 publishers and 2 subscribers. At that width it can step through all 256 security masks. For each mask it runs non-secure enable, set and clear writes and reads, and computes the expected vectors with plain bit arithmetic. It also crosses every channel with every publisher and subscriber security value under several masks. A hand-placed group configuration mixes secure and non-secure groups, which brings register- and event-triggered tasks, same-cycle ordering, and lock and reset behaviour within reach.

// File: rtl/evt_gate_pkg.sv
package evt_gate_pkg;

  localparam int ADDR_W = 6;
  localparam int GIDX_W = 4;

  typedef enum logic [3:0] {
    RK_NONE,
    RK_EN,
    RK_SET,
    RK_CLR,
    RK_MASK,
    RK_LOCK,
    RK_GCFG,
    RK_GEN,
    RK_GDIS
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e               kind;
    logic [GIDX_W-1:0]       gidx;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t r;
    r.gidx = a[GIDX_W-1:0];
    r.kind = RK_NONE;
    case (a[ADDR_W-1:GIDX_W])
      2'd0: begin
        case (a[GIDX_W-1:0])
          4'd0:    r.kind = RK_EN;
          4'd1:    r.kind = RK_SET;
          4'd2:    r.kind = RK_CLR;
          4'd3:    r.kind = RK_MASK;
          4'd4:    r.kind = RK_LOCK;
          default: r.kind = RK_NONE;
        endcase
      end
      2'd1:    r.kind = RK_GCFG;
      2'd2:    r.kind = RK_GEN;
      default: r.kind = RK_GDIS;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/evt_gate_cfg.sv
module evt_gate_cfg #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we_i,
  input  logic              lock_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] mask_o,
  output logic              lock_o
);

  logic [NUM_CH-1:0] mask_q;
  logic              lock_q;
  logic              mask_ce;
  logic              lock_ce;

  // clock enables: mask frozen once locked, lock only ever set
  always_comb begin
    mask_ce = mask_we_i & ~lock_q;
    lock_ce = lock_we_i & wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_ce) begin
      mask_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (lock_ce) begin
      lock_q <= 1'b1;
    end
  end

  assign mask_o = mask_q;
  assign lock_o = lock_q;

endmodule

// File: rtl/evt_gate_route.sv
module evt_gate_route #(
  parameter  int NUM_CH  = 32,
  parameter  int NUM_PUB = 4,
  parameter  int NUM_SUB = 4,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]       mask_i,
  input  logic [NUM_CH-1:0]       chan_en_i,
  input  logic [NUM_PUB-1:0]      pub_evt_i,
  input  logic [NUM_PUB*CH_W-1:0] pub_chan_i,
  input  logic [NUM_PUB-1:0]      pub_secure_i,
  input  logic [NUM_SUB-1:0]      sub_en_i,
  input  logic [NUM_SUB*CH_W-1:0] sub_chan_i,
  input  logic [NUM_SUB-1:0]      sub_secure_i,
  output logic [NUM_CH-1:0]       chan_evt_o,
  output logic [NUM_SUB-1:0]      sub_evt_o
);

  logic [NUM_CH-1:0] chan_evt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int p = 0; p < NUM_PUB; p++) begin
        if (pub_evt_i[p] &&
            (pub_chan_i[p*CH_W +: CH_W] == CH_W'(c)) &&
            (pub_secure_i[p] || !mask_i[c])) begin
          hit = 1'b1;
        end
      end
    end
    assign chan_evt[c] = hit & chan_en_i[c];
  end

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    logic [CH_W-1:0] sch;
    assign sch          = sub_chan_i[s*CH_W +: CH_W];
    assign sub_evt_o[s] = sub_en_i[s] & chan_evt[sch] &
                          (sub_secure_i[s] | ~mask_i[sch]);
  end

  assign chan_evt_o = chan_evt;

endmodule

// File: rtl/evt_gate_chan.sv
module evt_gate_chan
  import evt_gate_pkg::*;
#(
  parameter  int NUM_CH  = 32,
  parameter  int NUM_GRP = 6,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  reg_sel_t                sel_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic                    sec_i,
  input  logic [NUM_CH-1:0]       wdata_i,
  input  logic [NUM_CH-1:0]       mask_i,
  input  logic                    lock_i,
  input  logic [NUM_CH-1:0]       chan_evt_i,
  input  logic [NUM_GRP-1:0]      gen_sub_en_i,
  input  logic [NUM_GRP*CH_W-1:0] gen_sub_chan_i,
  input  logic [NUM_GRP-1:0]      gdis_sub_en_i,
  input  logic [NUM_GRP*CH_W-1:0] gdis_sub_chan_i,
  output logic [NUM_CH-1:0]       chan_en_o,
  output logic [NUM_CH-1:0]       rdata_o,
  output logic                    grp_fire_o
);

  logic [NUM_CH-1:0]  en_q;
  logic [NUM_CH-1:0]  en_nxt;
  logic [NUM_CH-1:0]  grp_q [NUM_GRP];
  logic [NUM_GRP-1:0] grp_sec;
  logic [NUM_GRP-1:0] grp_hit;
  logic [NUM_GRP-1:0] grp_grant;
  logic [NUM_GRP-1:0] grp_we;
  logic [NUM_GRP-1:0] fire_en;
  logic [NUM_GRP-1:0] fire_dis;
  logic [NUM_CH-1:0]  allow;

  // bit positions a transfer may touch
  assign allow = sec_i ? '1 : ~mask_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [CH_W-1:0] ech;
    logic [CH_W-1:0] dch;

    assign ech          = gen_sub_chan_i[g*CH_W +: CH_W];
    assign dch          = gdis_sub_chan_i[g*CH_W +: CH_W];
    assign grp_sec[g]   = |(grp_q[g] & mask_i);
    assign grp_hit[g]   = ({{(32-GIDX_W){1'b0}}, sel_i.gidx} == g);
    assign grp_grant[g] = sec_i | ~grp_sec[g];
    assign grp_we[g]    = wr_i & grp_hit[g] & (sel_i.kind == RK_GCFG) & grp_grant[g];

    assign fire_en[g]  = (wr_i & grp_hit[g] & (sel_i.kind == RK_GEN) & wdata_i[0] & grp_grant[g]) |
                         (gen_sub_en_i[g] & chan_evt_i[ech] & (mask_i[ech] | ~grp_sec[g]));
    assign fire_dis[g] = (wr_i & grp_hit[g] & (sel_i.kind == RK_GDIS) & wdata_i[0] & grp_grant[g]) |
                         (gdis_sub_en_i[g] & chan_evt_i[dch] & (mask_i[dch] | ~grp_sec[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        grp_q[g] <= '0;
      end else if (grp_we[g]) begin
        grp_q[g] <= wdata_i;
      end
    end
  end

  // next state: register write, then group disables, then group enables
  always_comb begin
    logic [NUM_CH-1:0] base;
    logic [NUM_CH-1:0] set_m;
    logic [NUM_CH-1:0] clr_m;
    base = en_q;
    if (wr_i) begin
      case (sel_i.kind)
        RK_EN:   base = (en_q & ~allow) | (wdata_i & allow);
        RK_SET:  base = en_q | (wdata_i & allow);
        RK_CLR:  base = en_q & ~(wdata_i & allow);
        default: base = en_q;
      endcase
    end
    set_m = '0;
    clr_m = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (fire_en[g])  set_m = set_m | grp_q[g];
      if (fire_dis[g]) clr_m = clr_m | grp_q[g];
    end
    en_nxt = (base & ~clr_m) | set_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_nxt;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (sel_i.kind)
        RK_EN, RK_SET, RK_CLR: rdata_o = en_q & allow;
        RK_MASK:               rdata_o = mask_i;
        RK_LOCK:               rdata_o = {{(NUM_CH-1){1'b0}}, lock_i};
        RK_GCFG: begin
          for (int g = 0; g < NUM_GRP; g++) begin
            if (grp_hit[g] && grp_grant[g]) rdata_o = grp_q[g];
          end
        end
        default:               rdata_o = '0;
      endcase
    end
  end

  assign chan_en_o  = en_q;
  assign grp_fire_o = |{fire_en, fire_dis};

endmodule

// File: rtl/evt_sec_gate.sv
module evt_sec_gate
  import evt_gate_pkg::*;
#(
  parameter  int NUM_CH  = 32,
  parameter  int NUM_GRP = 6,
  parameter  int NUM_PUB = 4,
  parameter  int NUM_SUB = 4,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_valid_i,
  input  logic                    bus_write_i,
  input  logic                    bus_secure_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [NUM_CH-1:0]       bus_wdata_i,
  output logic [NUM_CH-1:0]       bus_rdata_o,
  input  logic [NUM_PUB-1:0]      pub_evt_i,
  input  logic [NUM_PUB*CH_W-1:0] pub_chan_i,
  input  logic [NUM_PUB-1:0]      pub_secure_i,
  input  logic [NUM_SUB-1:0]      sub_en_i,
  input  logic [NUM_SUB*CH_W-1:0] sub_chan_i,
  input  logic [NUM_SUB-1:0]      sub_secure_i,
  output logic [NUM_SUB-1:0]      sub_evt_o,
  input  logic [NUM_GRP-1:0]      gen_sub_en_i,
  input  logic [NUM_GRP*CH_W-1:0] gen_sub_chan_i,
  input  logic [NUM_GRP-1:0]      gdis_sub_en_i,
  input  logic [NUM_GRP*CH_W-1:0] gdis_sub_chan_i,
  output logic [NUM_CH-1:0]       chan_evt_o,
  output logic [NUM_CH-1:0]       chan_en_o
);

  reg_sel_t          sel;
  logic              wr_stb;
  logic              rd_stb;
  logic [NUM_CH-1:0] mask_q;
  logic              lock_q;
  logic [NUM_CH-1:0] chan_en;
  logic [NUM_CH-1:0] chan_evt;
  logic              grp_fire;

  assign sel    = decode_addr(bus_addr_i);
  assign wr_stb = bus_valid_i & bus_write_i;
  assign rd_stb = bus_valid_i & ~bus_write_i;

  evt_gate_cfg #(
    .NUM_CH (NUM_CH)
  ) i_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we_i (wr_stb & bus_secure_i & (sel.kind == RK_MASK)),
    .lock_we_i (wr_stb & bus_secure_i & (sel.kind == RK_LOCK)),
    .wdata_i   (bus_wdata_i),
    .mask_o    (mask_q),
    .lock_o    (lock_q)
  );

  evt_gate_route #(
    .NUM_CH  (NUM_CH),
    .NUM_PUB (NUM_PUB),
    .NUM_SUB (NUM_SUB)
  ) i_route (
    .mask_i       (mask_q),
    .chan_en_i    (chan_en),
    .pub_evt_i    (pub_evt_i),
    .pub_chan_i   (pub_chan_i),
    .pub_secure_i (pub_secure_i),
    .sub_en_i     (sub_en_i),
    .sub_chan_i   (sub_chan_i),
    .sub_secure_i (sub_secure_i),
    .chan_evt_o   (chan_evt),
    .sub_evt_o    (sub_evt_o)
  );

  evt_gate_chan #(
    .NUM_CH  (NUM_CH),
    .NUM_GRP (NUM_GRP)
  ) i_chan (
    .clk             (clk),
    .rst_n           (rst_n),
    .sel_i           (sel),
    .wr_i            (wr_stb),
    .rd_i            (rd_stb),
    .sec_i           (bus_secure_i),
    .wdata_i         (bus_wdata_i),
    .mask_i          (mask_q),
    .lock_i          (lock_q),
    .chan_evt_i      (chan_evt),
    .gen_sub_en_i    (gen_sub_en_i),
    .gen_sub_chan_i  (gen_sub_chan_i),
    .gdis_sub_en_i   (gdis_sub_en_i),
    .gdis_sub_chan_i (gdis_sub_chan_i),
    .chan_en_o       (chan_en),
    .rdata_o         (bus_rdata_o),
    .grp_fire_o      (grp_fire)
  );

  assign chan_evt_o = chan_evt;
  assign chan_en_o  = chan_en;

endmodule

// File: rtl/evt_sec_gate_chk.sv
module evt_sec_gate_chk #(
  parameter  int NUM_CH  = 32,
  parameter  int NUM_SUB = 4,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_valid_i,
  input logic                    bus_write_i,
  input logic                    bus_secure_i,
  input logic [5:0]              bus_addr_i,
  input logic [NUM_CH-1:0]       bus_rdata_o,
  input logic [NUM_CH-1:0]       mask_q,
  input logic                    lock_q,
  input logic                    grp_fire,
  input logic [NUM_CH-1:0]       chan_en_o,
  input logic [NUM_CH-1:0]       chan_evt_o,
  input logic [NUM_SUB-1:0]      sub_evt_o,
  input logic [NUM_SUB*CH_W-1:0] sub_chan_i
);

  logic ns_en_access;
  assign ns_en_access = bus_valid_i & ~bus_secure_i & (bus_addr_i < 6'd3);

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R2

  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(mask_q)); // R2

  AST_EVT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_evt_o & ~chan_en_o) == '0); // R3

  AST_NS_WR_KEEPS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_en_access && bus_write_i && !grp_fire)
      |=> ((chan_en_o ^ $past(chan_en_o)) & $past(mask_q)) == '0); // R5

  AST_NS_RD_HIDES_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_en_access && !bus_write_i) |-> (bus_rdata_o & mask_q) == '0); // R6

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid_i && !bus_write_i) |-> bus_rdata_o == '0); // R11

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub_chk
    logic [CH_W-1:0] sch;
    assign sch = sub_chan_i[s*CH_W +: CH_W];
    AST_SUB_NEEDS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
      sub_evt_o[s] |-> chan_evt_o[sch]); // R4
  end

endmodule

bind evt_sec_gate evt_sec_gate_chk #(
  .NUM_CH  (NUM_CH),
  .NUM_SUB (NUM_SUB)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid_i  (bus_valid_i),
  .bus_write_i  (bus_write_i),
  .bus_secure_i (bus_secure_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .mask_q       (mask_q),
  .lock_q       (lock_q),
  .grp_fire     (grp_fire),
  .chan_en_o    (chan_en_o),
  .chan_evt_o   (chan_evt_o),
  .sub_evt_o    (sub_evt_o),
  .sub_chan_i   (sub_chan_i)
);

// File: tb/test_evt_sec_gate.sv
`timescale 1ns/1ps
module test_evt_sec_gate;

  localparam int NCH = 8;
  localparam int NG  = 4;
  localparam int NP  = 2;
  localparam int NS  = 2;
  localparam int CW  = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_valid = 1'b0;
  logic           bus_write = 1'b0;
  logic           bus_secure = 1'b0;
  logic [5:0]     bus_addr = '0;
  logic [NCH-1:0] bus_wdata = '0;
  logic [NCH-1:0] bus_rdata;
  logic [NP-1:0]  pub_evt = '0;
  logic [NP*CW-1:0] pub_chan = '0;
  logic [NP-1:0]  pub_sec = '0;
  logic [NS-1:0]  sub_en = '0;
  logic [NS*CW-1:0] sub_chan = '0;
  logic [NS-1:0]  sub_sec = '0;
  logic [NS-1:0]  sub_evt;
  logic [NG-1:0]  gen_en = '0;
  logic [NG*CW-1:0] gen_chan = '0;
  logic [NG-1:0]  gdis_en = '0;
  logic [NG*CW-1:0] gdis_chan = '0;
  logic [NCH-1:0] chan_evt;
  logic [NCH-1:0] chan_en;

  int n_total = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  evt_sec_gate #(
    .NUM_CH (NCH), .NUM_GRP (NG), .NUM_PUB (NP), .NUM_SUB (NS)
  ) i_evt_sec_gate (
    .clk (clk), .rst_n (rst_n),
    .bus_valid_i (bus_valid), .bus_write_i (bus_write), .bus_secure_i (bus_secure),
    .bus_addr_i (bus_addr), .bus_wdata_i (bus_wdata), .bus_rdata_o (bus_rdata),
    .pub_evt_i (pub_evt), .pub_chan_i (pub_chan), .pub_secure_i (pub_sec),
    .sub_en_i (sub_en), .sub_chan_i (sub_chan), .sub_secure_i (sub_sec),
    .sub_evt_o (sub_evt),
    .gen_sub_en_i (gen_en), .gen_sub_chan_i (gen_chan),
    .gdis_sub_en_i (gdis_en), .gdis_sub_chan_i (gdis_chan),
    .chan_evt_o (chan_evt), .chan_en_o (chan_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [NCH-1:0] d, input logic s);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_secure = s;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic s, output logic [NCH-1:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_secure = s;
    #2;
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog R1-R11 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [NCH-1:0] m, p, q, r, d, m_en, ce;
    logic [NCH-1:0] masks [4];

    // reset state
    do_reset();
    @(negedge clk);
    chk("R1 enables after reset", chan_en, 8'h00);
    rd(6'd3, 1'b1, d); chk("R1 mask after reset", d, 8'hFF);
    rd(6'd4, 1'b1, d); chk("R1 lock after reset", d, 8'h00);
    rd(6'd17, 1'b1, d); chk("R1 group cfg after reset", d, 8'h00);
    chk("R11 idle rdata", bus_rdata, 8'h00);

    // exhaustive mask sweep over enable/set/clear accesses
    m_en = 8'h00;
    for (int mi = 0; mi < 256; mi++) begin
      m = mi[7:0];
      wr(6'd3, m, 1'b1);
      wr(6'd3, ~m, 1'b0);
      rd(6'd3, 1'b1, d); chk("R2 ns mask write ignored", d, m);
      p = 8'((mi * 37 + 11) & 255);
      wr(6'd0, p, 1'b0);
      m_en = (m_en & m) | (p & ~m);
      chk("R5 ns enable write", chan_en, m_en);
      rd(6'd0, 1'b0, d); chk("R6 ns enable read", d, m_en & ~m);
      rd(6'd0, 1'b1, d); chk("R6 secure enable read", d, m_en);
      q = 8'((mi * 91 + 5) & 255);
      wr(6'd1, q, 1'b0);
      m_en = m_en | (q & ~m);
      chk("R5 ns set write", chan_en, m_en);
      r = 8'((mi * 53 + 200) & 255);
      wr(6'd2, r, 1'b0);
      m_en = m_en & ~(r & ~m);
      chk("R5 ns clear write", chan_en, m_en);
      rd(6'd2, 1'b0, d); chk("R6 ns clear-reg read", d, m_en & ~m);
      if ((mi % 16) == 0) begin
        wr(6'd0, p ^ 8'h5A, 1'b1);
        m_en = p ^ 8'h5A;
        chk("R5 secure enable write", chan_en, m_en);
      end
    end

    // publish / subscribe crossing
    masks[0] = 8'hA5; masks[1] = 8'h5A; masks[2] = 8'h00; masks[3] = 8'hFF;
    for (int k = 0; k < 4; k++) begin
      m = masks[k];
      wr(6'd3, m, 1'b1);
      wr(6'd0, 8'hFF, 1'b1);
      for (int c = 0; c < NCH; c++) begin
        for (int s = 0; s < 2; s++) begin
          for (int s2 = 0; s2 < 2; s2++) begin
            @(negedge clk);
            pub_evt = 2'b01; pub_chan = 6'(c); pub_sec = 2'(s);
            sub_en = 2'b01; sub_chan = 6'(c); sub_sec = 2'(s2);
            #2;
            ce = (s == 1 || !m[c]) ? (8'h01 << c) : 8'h00;
            chk("R3 channel event gating", chan_evt, ce);
            chk("R4 subscriber gating", {31'b0, sub_evt[0]},
                {31'b0, ce[c] & ((s2 == 1) || !m[c])});
            pub_evt = '0; sub_en = '0;
          end
        end
      end
      wr(6'd0, 8'h00, 1'b1);
      @(negedge clk);
      pub_evt = 2'b10; pub_chan = 6'(3 << 3); pub_sec = 2'b10;
      #2;
      chk("R3 disabled channel silent", chan_evt, 8'h00);
      pub_evt = '0;
    end

    // groups: channels 0..3 secure
    wr(6'd3, 8'h0F, 1'b1);
    wr(6'd0, 8'h00, 1'b1);
    wr(6'd16, 8'h30, 1'b1);
    wr(6'd17, 8'h18, 1'b1);
    wr(6'd18, 8'h81, 1'b1);
    wr(6'd19, 8'hC0, 1'b1);
    rd(6'd16, 1'b0, d); chk("R7 ns read of ns group", d, 8'h30);
    rd(6'd17, 1'b0, d); chk("R7 ns read of secure group", d, 8'h00);
    rd(6'd18, 1'b0, d); chk("R7 ns read of disabled-secure group", d, 8'h00);
    rd(6'd19, 1'b0, d); chk("R7 ns read of ns group 3", d, 8'hC0);
    wr(6'd17, 8'hFF, 1'b0);
    rd(6'd17, 1'b1, d); chk("R7 ns write to secure group ignored", d, 8'h18);
    wr(6'd16, 8'h70, 1'b0);
    rd(6'd16, 1'b1, d); chk("R7 ns write to ns group", d, 8'h70);

    wr(6'd33, 8'h01, 1'b0); chk("R8 ns enable task on secure group", chan_en, 8'h00);
    wr(6'd32, 8'h01, 1'b0); chk("R8 ns enable task on ns group", chan_en, 8'h70);
    wr(6'd51, 8'h01, 1'b0); chk("R8 ns disable task", chan_en, 8'h30);
    wr(6'd33, 8'h01, 1'b1); chk("R8 secure enable task", chan_en, 8'h38);
    wr(6'd49, 8'h01, 1'b0); chk("R8 ns disable on secure group", chan_en, 8'h38);
    wr(6'd49, 8'h01, 1'b1); chk("R8 secure disable task", chan_en, 8'h20);
    rd(6'd32, 1'b1, d); chk("R11 task address reads zero", d, 8'h00);
    rd(6'd10, 1'b1, d); chk("R11 unmapped read zero", d, 8'h00);

    // event-driven tasks
    @(negedge clk);
    gen_en = 4'b0010; gen_chan = 12'(5 << 3);
    pub_evt = 2'b01; pub_chan = 6'd5; pub_sec = 2'b01;
    @(negedge clk);
    pub_evt = '0; gen_en = '0;
    chk("R9 ns channel into secure group ignored", chan_en, 8'h20);
    @(negedge clk);
    gen_en = 4'b1000; gen_chan = 12'(5 << 9);
    pub_evt = 2'b01; pub_chan = 6'd5; pub_sec = 2'b01;
    @(negedge clk);
    pub_evt = '0; gen_en = '0;
    chk("R9 ns channel into ns group", chan_en, 8'hE0);
    wr(6'd1, 8'h08, 1'b1);
    @(negedge clk);
    gdis_en = 4'b1000; gdis_chan = 12'(3 << 9);
    pub_evt = 2'b01; pub_chan = 6'd3; pub_sec = 2'b01;
    @(negedge clk);
    pub_evt = '0; gdis_en = '0;
    chk("R9 secure channel into ns group", chan_en, 8'h28);

    // same-cycle ordering
    @(negedge clk);
    gen_en = 4'b0001; gen_chan = 12'd5;
    pub_evt = 2'b01; pub_chan = 6'd5; pub_sec = 2'b01;
    bus_valid = 1'b1; bus_write = 1'b1; bus_secure = 1'b1; bus_addr = 6'd0; bus_wdata = 8'h00;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; pub_evt = '0; gen_en = '0;
    chk("R10 group enable after register write", chan_en, 8'h70);
    @(negedge clk);
    gdis_en = 4'b0001; gdis_chan = 12'd5;
    gen_en = 4'b1000; gen_chan = 12'(5 << 9);
    pub_evt = 2'b01; pub_chan = 6'd5; pub_sec = 2'b01;
    @(negedge clk);
    pub_evt = '0; gen_en = '0; gdis_en = '0;
    chk("R10 enable applied after disable", chan_en, 8'hC0);

    // lock
    wr(6'd4, 8'h01, 1'b0);
    rd(6'd4, 1'b1, d); chk("R2 ns lock write ignored", d, 8'h00);
    wr(6'd4, 8'h01, 1'b1);
    rd(6'd4, 1'b1, d); chk("R2 lock set", d, 8'h01);
    wr(6'd3, 8'h00, 1'b1);
    rd(6'd3, 1'b1, d); chk("R2 mask frozen by lock", d, 8'h0F);
    wr(6'd4, 8'h00, 1'b1);
    rd(6'd4, 1'b1, d); chk("R2 lock sticky", d, 8'h01);

    do_reset();
    @(negedge clk);
    rd(6'd3, 1'b1, d); chk("R1 mask restored by reset", d, 8'hFF);
    rd(6'd4, 1'b1, d); chk("R1 lock cleared by reset", d, 8'h00);
    rd(6'd16, 1'b1, d); chk("R1 group cleared by reset", d, 8'h00);
    chk("R1 enables cleared by reset", chan_en, 8'h00);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule